// File: doc/BRIEF.md
# Calibration Strobe and Delayed Trigger Sequencer

This block runs a two-phase calibration sequence. A calibrate command seen while the block is idle produces a strobe to the front-end that lasts exactly one clock. The block then counts a programmable gap and raises a one-clock trigger request, which feeds the normal trigger path. A busy flag covers the strobe and the whole gap, and it drops in the cycle the trigger starts.

The gap is 42 plus a 4-bit setting, in clock cycles. That gives 42 to 57 cycles, or about 4.0 to 5.5 us at a 96 ns clock. The setting is captured when the command is accepted. While a sequence is running, further commands are dropped. Calibrate and ordinary trigger commands have no priority between them. Issuing both in the same cycle is illegal, so the block does no arbitration.

Top module: `cal_seq`

## Requirements
- R1: A calibrate command sampled high at a rising edge while the block is idle makes `cal_strobe` high for exactly the one cycle after that edge.
- R2: Let D be 42 plus the value of `gap_sel` (0 to 15). `cal_trig` is high for exactly one cycle, D cycles after the cycle in which the strobe is high.
- R3: `cal_busy` is high in the strobe cycle and in every cycle up to the trigger. That is D cycles in all. It is low in the trigger cycle.
- R4: A calibrate command sampled during the strobe, the gap or the trigger cycle has no effect. No extra strobe appears and the trigger timing does not change.
- R5: `gap_sel` is captured when the command is accepted. Changing it during a running sequence does not move that sequence's trigger.
- R6: After the trigger cycle the block is idle with all outputs low. A command sampled in the first idle cycle starts a new sequence.
- R7: While `rst_n` is low, all outputs are low. A reset in mid-sequence abandons it, so no trigger follows after release.
- R8: `cal_strobe` and `cal_trig` are never high in the same cycle, and `cal_trig` only occurs at the end of a busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_cmd | input | 1 | Calibrate command, sampled each rising edge |
| gap_sel | input | 4 | Extra gap cycles added to the 42-cycle base |
| cal_strobe | output | 1 | One-clock calibration strobe to the front-end |
| cal_trig | output | 1 | One-clock automatic calibration trigger request |
| cal_busy | output | 1 | High from strobe start until trigger start |

## Verification
Take the rising edge at which the command is accepted as edge zero. The strobe is due in the cycle right after that edge. The busy flag then stays high for D cycles, and the trigger is due D cycles after the strobe cycle. The bench drives inputs on falling edges and samples all three outputs on every falling edge. It compares each cycle against these formulas for every one of the 16 settings. Commands injected during the strobe, the gap and the trigger cycle, and a change of setting mid-gap, are checked by confirming that this same cycle-exact trace still holds.

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int SEL_W    = 4,
  parameter int BASE_GAP = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_cmd,
  input  logic [SEL_W-1:0] gap_sel,
  output logic             cal_strobe,
  output logic             cal_trig,
  output logic             cal_busy
);
  localparam int GAP_MAX = BASE_GAP + (1 << SEL_W) - 1;
  localparam int CW      = $clog2(GAP_MAX);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_WAIT, S_FIRE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cal_cmd) begin
          st  <= S_STROBE;
          cnt <= CW'(BASE_GAP - 2) + CW'(gap_sel);
        end
        S_STROBE: st <= S_WAIT;
        S_WAIT: begin
          if (cnt == '0) st <= S_FIRE;
          else           cnt <= cnt - 1'b1;
        end
        S_FIRE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cal_strobe = (st == S_STROBE);
  assign cal_trig   = (st == S_FIRE);
  assign cal_busy   = (st == S_STROBE) || (st == S_WAIT);
endmodule

module cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cal_cmd,
  input logic cal_strobe,
  input logic cal_trig,
  input logic cal_busy
);
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_strobe |=> !cal_strobe);
  a_r2_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_trig |=> !cal_trig);
  a_r3_busy_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cal_strobe |-> cal_busy);
  a_r3_busy_ends_at_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> cal_trig);
  a_r4_cmd_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && cal_cmd) |=> !cal_strobe);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_strobe, cal_trig}));
  a_r8_trig_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_trig |-> $past(cal_busy));

  always @(posedge clk)
    if (!rst_n)
      a_r7_reset_quiet: assert (!cal_strobe && !cal_trig && !cal_busy);
endmodule

bind cal_seq cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cal_cmd(cal_cmd),
  .cal_strobe(cal_strobe), .cal_trig(cal_trig), .cal_busy(cal_busy)
);

// File: tb/tb_cal_seq.sv
module tb_cal_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_cmd = 1'b0;
  logic [3:0] gap_sel = '0;
  logic       cal_strobe, cal_trig, cal_busy;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_seq dut (
    .clk(clk), .rst_n(rst_n), .cal_cmd(cal_cmd), .gap_sel(gap_sel),
    .cal_strobe(cal_strobe), .cal_trig(cal_trig), .cal_busy(cal_busy)
  );

  task automatic check(input string tag, input int k, input logic [2:0] exp);
    logic [2:0] act;
    act = {cal_strobe, cal_busy, cal_trig};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d {strobe,busy,trig} actual=%b expected=%b", tag, k, act, exp);
    end
  endtask

  // mode 0: plain; 1: commands during strobe and gap, setting changed mid-gap;
  // 2: command held across trigger cycle into first idle cycle
  task automatic run_seq(input int sel, input int mode);
    int d;
    string tag;
    d = 42 + sel;
    gap_sel = 4'(sel);
    @(negedge clk) cal_cmd = 1'b1;
    for (int k = 0; k <= d + 1; k++) begin
      @(negedge clk);
      if (k == 0) tag = "R1";
      else if (k < d) tag = (mode == 1) ? "R4/R5 R3" : "R3";
      else if (k == d) tag = (mode == 1) ? "R4 R2" : "R2";
      else tag = (mode == 2) ? "R4 R6" : "R6";
      check(tag, k, {k == 0, k < d, k == d});
      cal_cmd = 1'b0;
      if (mode == 1) begin
        if (k == 0 || k == 20) cal_cmd = 1'b1;
        if (k == 3) gap_sel = ~4'(sel);
      end
      if (mode == 2 && k >= d) cal_cmd = 1'b1;
    end
    if (mode == 2) begin
      @(negedge clk);
      check("R6 restart", d + 2, 3'b110);
      cal_cmd = 1'b0;
      repeat (d + 2) @(negedge clk);
      check("R6 restart idle", 2 * d + 4, 3'b000);
    end
    cal_cmd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset state", 0, 3'b000);
    cal_cmd = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 cmd in reset", 0, 3'b000);
    cal_cmd = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 16; s++) run_seq(s, 0);
    for (int s = 0; s < 16; s++) run_seq(s, 1);
    run_seq(0, 2);
    run_seq(15, 2);

    gap_sel = 4'd5;
    @(negedge clk) cal_cmd = 1'b1;
    @(negedge clk) cal_cmd = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1 check("R7 async reset mid-gap", 0, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      check("R7 no trigger after reset", k, 3'b000);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule